// File: doc/BRIEF.md
# Input-Triggered Pulse Burst Generator

This block watches a pair of single-bit trigger inputs and answers with a short run of high cycles on one output. While it is idle, an input pair whose two bits agree leaves it idle. The pattern with only trigger A high starts a run of one high cycle. The pattern with only trigger B high starts a run of two high cycles. After a run it goes back to idle.

The block is a Moore machine with four states: idle, single, burst first half and burst second half. The output is decoded from the registered state alone, so a run starts one clock after the trigger is sampled. The inputs have no combinational path to the output. While a run is in progress the inputs are not looked at. A parameter selects either a binary or a one-hot state register, and both give the same behaviour at the ports.

Top module: `pulse_burst_gen`

## Requirements
- R1: While rst_ni is low, and right after it is released, pulse_o is 0 and the machine is idle.
- R2: In idle, an input pair {trig_b_i, trig_a_i} of 00 or 11 keeps the machine idle with pulse_o at 0.
- R3: In idle, {trig_b_i, trig_a_i} = 01 at a clock edge makes pulse_o 1 for exactly the next clock cycle, then 0.
- R4: In idle, {trig_b_i, trig_a_i} = 10 at a clock edge makes pulse_o 1 for exactly the next two clock cycles, then 0.
- R5: Input values sampled while a run is in progress have no effect: the run keeps its length and the machine returns to idle.
- R6: pulse_o changes only at a rising clock edge or at reset. A change on the inputs between edges leaves it unchanged.
- R7: The inputs are sampled again at the first edge where the machine is back in idle, so a trigger there starts a new run right after the previous one.
- R8: Pulling rst_ni low during a burst drops pulse_o to 0 at once, without a clock edge, and the burst does not resume after release.
- R9: With ONE_HOT set to 0 (binary state register) or 1 (one-hot state register), the sequence on pulse_o is the same, and in the one-hot variant exactly one state bit is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_a_i | input | 1 | Trigger A; high alone requests a single pulse |
| trig_b_i | input | 1 | Trigger B; high alone requests a two-cycle burst |
| pulse_o | output | 1 | Registered-state decoded pulse output |

## Verification
The bench builds two instances side by side. One uses ONE_HOT = 0 (binary state code) and the other ONE_HOT = 1 (one-hot code). Both get the same stimulus and each check is made against both outputs. This brings the encoding equivalence and the one-hot invariant within reach of the same directed sequences. The sequences replay a mixed trigger trace and then cover back-to-back runs, input changes between edges, and a reset in the middle of a burst.

// File: rtl/pulse_burst_pkg.sv
package pulse_burst_pkg;
  typedef enum logic [1:0] {
    PB_IDLE    = 2'd0,
    PB_SINGLE  = 2'd1,
    PB_BURST_A = 2'd2,
    PB_BURST_B = 2'd3
  } pb_state_e;

  localparam int unsigned PB_NUM_STATES = 4;
endpackage

// File: rtl/pb_next_state.sv
module pb_next_state
  import pulse_burst_pkg::*;
(
  input  pb_state_e state_i,
  input  logic      trig_a_i,
  input  logic      trig_b_i,
  output pb_state_e next_o
);
  always_comb begin
    next_o = PB_IDLE;
    unique case (state_i)
      PB_IDLE: begin
        if (trig_a_i && !trig_b_i)      next_o = PB_SINGLE;
        else if (trig_b_i && !trig_a_i) next_o = PB_BURST_A;
        else                            next_o = PB_IDLE;
      end
      PB_BURST_A: next_o = PB_BURST_B;
      // single and burst tail both end the run; inputs not consulted
      default:    next_o = PB_IDLE;
    endcase
  end
endmodule

// File: rtl/pb_state_reg.sv
module pb_state_reg
  import pulse_burst_pkg::*;
#(
  parameter bit ONE_HOT = 1'b0
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  pb_state_e next_i,
  output pb_state_e state_o,
  output logic      pulse_o
);
  localparam int unsigned SW = ONE_HOT ? PB_NUM_STATES : $clog2(PB_NUM_STATES);
  localparam logic [SW-1:0] RST_CODE = SW'(ONE_HOT ? 1 : 0);

  logic [SW-1:0] code_d, code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) code_q <= RST_CODE;
    else         code_q <= code_d;
  end

  generate
    if (ONE_HOT) begin : g_onehot
      always_comb begin
        code_d = '0;
        code_d[next_i] = 1'b1;
      end

      always_comb begin
        state_o = PB_IDLE;
        for (int i = 0; i < PB_NUM_STATES; i++) begin
          if (code_q[i]) state_o = pb_state_e'(2'(i));
        end
      end

      // idle is bit 0; every other state drives the output high
      assign pulse_o = ~code_q[0];

      p_onehot_code_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones(code_q) == 1);
    end else begin : g_binary
      assign code_d  = SW'(next_i);
      assign state_o = pb_state_e'(code_q);
      assign pulse_o = |code_q;
    end
  endgenerate
endmodule

// File: rtl/pulse_burst_gen.sv
module pulse_burst_gen
  import pulse_burst_pkg::*;
#(
  parameter bit ONE_HOT = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_a_i,
  input  logic trig_b_i,
  output logic pulse_o
);
  pb_state_e state, next_state;

  pb_next_state u_next (
    .state_i  (state),
    .trig_a_i (trig_a_i),
    .trig_b_i (trig_b_i),
    .next_o   (next_state)
  );

  pb_state_reg #(.ONE_HOT(ONE_HOT)) u_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .next_i  (next_state),
    .state_o (state),
    .pulse_o (pulse_o)
  );

  p_hold_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == PB_IDLE && trig_a_i == trig_b_i) |=> (state == PB_IDLE && !pulse_o));

  p_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == PB_IDLE && trig_a_i && !trig_b_i) |=> pulse_o ##1 !pulse_o);

  p_burst_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == PB_IDLE && trig_b_i && !trig_a_i) |=> pulse_o ##1 pulse_o ##1 !pulse_o);

  p_run_ends_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == PB_SINGLE || state == PB_BURST_B) |=> (state == PB_IDLE));

  p_state_output_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(state) |-> $stable(pulse_o));

  p_rearm_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(state) != PB_IDLE && state == PB_IDLE && trig_a_i != trig_b_i) |=> pulse_o);
endmodule

// File: tb/pulse_burst_gen_tb_top.sv
`timescale 1ns/1ps
module pulse_burst_gen_tb_top;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b1;
  logic trig_a_i = 1'b0;
  logic trig_b_i = 1'b0;
  logic pulse_bin, pulse_oh;
  int   n_checks = 0;
  int   n_fails  = 0;
  bit   done     = 1'b0;

  always #2 clk_i = ~clk_i;

  pulse_burst_gen #(.ONE_HOT(1'b0)) dut_i (
    .clk_i (clk_i), .rst_ni (rst_ni), .trig_a_i (trig_a_i),
    .trig_b_i (trig_b_i), .pulse_o (pulse_bin)
  );

  pulse_burst_gen #(.ONE_HOT(1'b1)) dut_oh_i (
    .clk_i (clk_i), .rst_ni (rst_ni), .trig_a_i (trig_a_i),
    .trig_b_i (trig_b_i), .pulse_o (pulse_oh)
  );

  task automatic check(input logic exp, input string req);
    n_checks++;
    if (pulse_bin !== exp) begin
      n_fails++;
      $display("FAIL %s binary: pulse_o=%0b expected %0b at %0t", req, pulse_bin, exp, $time);
    end
    n_checks++;
    if (pulse_oh !== exp) begin
      n_fails++;
      $display("FAIL %s R9 one-hot: pulse_o=%0b expected %0b at %0t", req, pulse_oh, exp, $time);
    end
  endtask

  // one cycle: at a falling edge check the output, then drive the next inputs
  task automatic step(input logic [1:0] ba, input logic exp, input string req);
    @(negedge clk_i);
    check(exp, req);
    {trig_b_i, trig_a_i} = ba;
  endtask

  task automatic t_reset();
    {trig_b_i, trig_a_i} = 2'b00;
    #1 rst_ni = 1'b0;
    @(negedge clk_i);
    check(1'b0, "R1 in reset");
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(posedge clk_i);
    #1 check(1'b0, "R1 after release");
  endtask

  task automatic t_trace();
    logic [1:0] x [11] = '{2'b00, 2'b11, 2'b10, 2'b10, 2'b10, 2'b00,
                           2'b01, 2'b01, 2'b10, 2'b00, 2'b00};
    logic       z [11] = '{0, 0, 0, 1, 1, 0, 0, 1, 0, 1, 1};
    for (int t = 0; t < 11; t++) step(x[t], z[t], "R2/R3/R4/R5/R7 trace");
    step(2'b00, 1'b0, "R4 burst ends");
    step(2'b00, 1'b0, "R2 idle");
  endtask

  task automatic t_back_to_back();
    step(2'b01, 1'b0, "R2 idle before single");
    step(2'b11, 1'b1, "R3 single high");
    step(2'b00, 1'b0, "R5 input 11 ignored, single over");
    step(2'b10, 1'b0, "R2 idle");
    step(2'b01, 1'b1, "R4 burst first");
    step(2'b10, 1'b1, "R5 burst second despite 01");
    step(2'b01, 1'b0, "R7 back in idle, 10 ignored");
    step(2'b00, 1'b1, "R7 rearmed single");
    step(2'b00, 1'b0, "R3 single over");
  endtask

  task automatic t_between_edges();
    @(negedge clk_i);
    {trig_b_i, trig_a_i} = 2'b01;
    #1 check(1'b0, "R6 no comb path 01");
    {trig_b_i, trig_a_i} = 2'b10;
    #0.5 check(1'b0, "R6 no comb path 10");
    @(negedge clk_i);
    check(1'b1, "R4 burst from 10");
    {trig_b_i, trig_a_i} = 2'b00;
    #1 check(1'b1, "R6 stable mid-cycle");
    @(negedge clk_i);
    check(1'b1, "R4 burst second");
    @(negedge clk_i);
    check(1'b0, "R4 burst done");
  endtask

  task automatic t_reset_mid_burst();
    step(2'b10, 1'b0, "R2 idle before burst");
    step(2'b00, 1'b1, "R4 burst first");
    #1 rst_ni = 1'b0;
    #0.5 check(1'b0, "R8 async drop");
    @(negedge clk_i);
    check(1'b0, "R8 held in reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(1'b0, "R8 burst not resumed");
    step(2'b00, 1'b0, "R8 idle");
  endtask

  initial begin
    t_reset();
    t_trace();
    t_back_to_back();
    t_between_edges();
    t_reset_mid_burst();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: run=hung expected=complete");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule